// File: doc/BRIEF.md
# Credit-Gated Flit Transmitter

This block is the transmit half of a point-to-point link layer. It takes 72-bit messages on a valid/ready input and adds an 8-bit CRC to each one, which makes an 80-bit flit. It sends the flit as four 20-bit phits on four back-to-back cycles, starting with the most significant phit. A marker flags the first phit of each flit.

The receiver sets the pace through buffer credits. An init pulse loads the credit count. Each flit that starts spends one credit. Each return pulse from the receiver gives one credit back. A message is accepted only when the serializer is idle and at least one credit is held.

Top module: `flit_credit_tx`

## Requirements
- R1: While reset is held, and afterwards until the first init, `pl_ready_o`, `phit_valid_o` and `phit_start_o` are low, and no flit is sent.
- R2: In a cycle with `init_i` high, `pl_ready_o` is low. At that clock edge the credit count and its ceiling are both loaded with `init_credits_i`. A credit return in that same cycle is ignored.
- R3: Each flit is `{payload, crc}`, with the CRC in bits 7:0. The CRC is CRC-8 with polynomial 0x07 and initial value 0x00. It is computed most-significant-bit first over the 72 payload bits, with no final XOR.
- R4: A flit goes out as four phits on four consecutive cycles with `phit_valid_o` high: flit bits 79:60, then 59:40, then 39:20, then 19:0.
- R5: `phit_start_o` is high on the first phit of a flit and low on the other three.
- R6: `pl_ready_o` is high only while no phit is being sent and the credit count is non-zero. An accepted message puts its first phit on the outputs in the next cycle. After the fourth phit there is one idle cycle.
- R7: Each accepted flit spends one credit. With N credits and no returns, exactly N flits are accepted. After that `pl_ready_o` stays low and no phits appear.
- R8: A return pulse adds one credit. A return in the same cycle that a flit is accepted leaves the count unchanged.
- R9: The credit count never goes above the value last loaded by init. Returns at that ceiling are dropped.
- R10: A flit that has started always sends all four phits, even when it spent the last credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Loads the credit count and ceiling |
| init_credits_i | input | 8 | Credit value loaded by init |
| credit_ret_i | input | 1 | One-cycle pulse that returns one credit |
| pl_valid_i | input | 1 | Payload valid |
| pl_data_i | input | 72 | Payload message |
| pl_ready_o | output | 1 | Payload accepted this cycle if valid |
| phit_o | output | 20 | Current phit |
| phit_valid_o | output | 1 | Phit output is valid |
| phit_start_o | output | 1 | First phit of a flit |

## Verification
Directed payloads test specific parts of the output:
- All zeros gives a zero CRC, which isolates the slicing of the phits.
- All ones exercises every feedback tap of the CRC.
- A single low bit shows that the CRC lands in the low byte and is computed MSB-first.

Directed credit sequences test the credit rules:
- An init that collides with a return shows which one wins.
- A return in the same cycle as an accept shows the count stays unchanged.
- Repeated returns at the ceiling show the count saturates.
- Draining the credits to zero shows the block stops exactly at the loaded count.

A seeded random mix of sends, returns and simultaneous send-and-return then checks the acceptance decision and the phit data against a credit model kept in the bench.

// File: rtl/flit_credit_tx.sv
module flit_credit_tx #(
  parameter int PAYLOAD_W = 72,
  parameter int CRC_W     = 8,
  parameter int PHIT_W    = 20,
  parameter int CREDIT_W  = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_i,
  input  logic [CREDIT_W-1:0]  init_credits_i,
  input  logic                 credit_ret_i,
  input  logic                 pl_valid_i,
  input  logic [PAYLOAD_W-1:0] pl_data_i,
  output logic                 pl_ready_o,
  output logic [PHIT_W-1:0]    phit_o,
  output logic                 phit_valid_o,
  output logic                 phit_start_o
);
  localparam int FLIT_W = PAYLOAD_W + CRC_W;
  localparam int NPHIT  = FLIT_W / PHIT_W;
  localparam int IDX_W  = (NPHIT > 1) ? $clog2(NPHIT) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPHIT - 1);

  logic                busy_q;
  logic [IDX_W-1:0]    idx_q;
  logic [FLIT_W-1:0]   sh_q;
  logic [CREDIT_W-1:0] credit_q, limit_q;
  logic [CRC_W-1:0]    crc;
  logic                accept;

  always_comb begin
    crc = '0;
    for (int i = PAYLOAD_W - 1; i >= 0; i--) begin
      if (crc[CRC_W-1] ^ pl_data_i[i]) crc = {crc[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                             crc = {crc[CRC_W-2:0], 1'b0};
    end
  end

  assign pl_ready_o   = !busy_q && !init_i && (credit_q != '0);
  assign accept       = pl_valid_i && pl_ready_o;
  assign phit_o       = sh_q[FLIT_W-1 -: PHIT_W];
  assign phit_valid_o = busy_q;
  assign phit_start_o = busy_q && (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      sh_q   <= {pl_data_i, crc};
    end else if (busy_q) begin
      sh_q  <= sh_q << PHIT_W;
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST_IDX) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= '0;
      limit_q  <= '0;
    end else if (init_i) begin
      credit_q <= init_credits_i;
      limit_q  <= init_credits_i;
    end else begin
      case ({credit_ret_i, accept})
        2'b01:   credit_q <= credit_q - 1'b1;
        2'b10:   if (credit_q != limit_q) credit_q <= credit_q + 1'b1;
        default: credit_q <= credit_q;
      endcase
    end
  end
endmodule

// File: rtl/flit_credit_tx_chk.sv
module flit_credit_tx_chk #(
  parameter int CREDIT_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                init_i,
  input logic                credit_ret_i,
  input logic                pl_valid_i,
  input logic                pl_ready_o,
  input logic                phit_valid_o,
  input logic                phit_start_o,
  input logic [CREDIT_W-1:0] credit_q,
  input logic [CREDIT_W-1:0] limit_q
);
  AST_INIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |-> !pl_ready_o); // R2
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    pl_valid_i && pl_ready_o |=> phit_start_o); // R6
  AST_START_HAS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    phit_start_o |-> $past(credit_q) != '0); // R7
  AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pl_valid_i && pl_ready_o) && $past(credit_ret_i) && !$past(init_i) |-> $stable(credit_q)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q <= limit_q); // R9
  AST_FLIT_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    phit_start_o |=> phit_valid_o && !phit_start_o); // R10
endmodule

bind flit_credit_tx flit_credit_tx_chk #(.CREDIT_W(CREDIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_i(init_i), .credit_ret_i(credit_ret_i),
  .pl_valid_i(pl_valid_i), .pl_ready_o(pl_ready_o), .phit_valid_o(phit_valid_o),
  .phit_start_o(phit_start_o), .credit_q(credit_q), .limit_q(limit_q)
);

// File: tb/test_flit_credit_tx.sv
`timescale 1ns/1ps
module test_flit_credit_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_i = 1'b0;
  logic [7:0]  init_credits_i = '0;
  logic        credit_ret_i = 1'b0;
  logic        pl_valid_i = 1'b0;
  logic [71:0] pl_data_i = '0;
  logic        pl_ready_o;
  logic [19:0] phit_o;
  logic        phit_valid_o;
  logic        phit_start_o;

  int checks = 0;
  int errors = 0;
  int mcred = 0;
  int mlim = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flit_credit_tx i_flit_credit_tx (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .init_credits_i(init_credits_i),
    .credit_ret_i(credit_ret_i), .pl_valid_i(pl_valid_i), .pl_data_i(pl_data_i),
    .pl_ready_o(pl_ready_o), .phit_o(phit_o), .phit_valid_o(phit_valid_o),
    .phit_start_o(phit_start_o)
  );

  function automatic logic [7:0] ref_crc(input logic [71:0] d);
    logic [79:0] r;
    r = {d, 8'h00};
    for (int i = 79; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_ret();
    if (mcred < mlim) mcred++;
  endtask

  task automatic do_init(input int n, input logic ret);
    init_i = 1'b1; init_credits_i = 8'(n); credit_ret_i = ret;
    #1 check("R2 ready low during init", {79'd0, pl_ready_o}, 80'd0);
    @(negedge clk);
    init_i = 1'b0; credit_ret_i = 1'b0;
    mcred = n; mlim = n;
  endtask

  task automatic ret_pulse();
    credit_ret_i = 1'b1;
    @(negedge clk);
    credit_ret_i = 1'b0;
    model_ret();
  endtask

  task automatic send(input logic [71:0] d, input logic ret, input string req);
    logic [79:0] flit;
    logic exp_rdy;
    flit = {d, ref_crc(d)};
    pl_valid_i = 1'b1; pl_data_i = d; credit_ret_i = ret;
    exp_rdy = (mcred != 0);
    #1 check({req, " R6 ready"}, {79'd0, pl_ready_o}, {79'd0, exp_rdy});
    @(negedge clk);
    pl_valid_i = 1'b0; credit_ret_i = 1'b0;
    if (!exp_rdy) begin
      if (ret) model_ret();
      check({req, " R7 no phit without credit"}, {79'd0, phit_valid_o}, 80'd0);
      return;
    end
    if (!ret) mcred--;
    for (int k = 0; k < 4; k++) begin
      check({req, " R4 phit data"}, {60'd0, phit_o}, {60'd0, flit[79-20*k -: 20]});
      check({req, " R10 phit valid"}, {79'd0, phit_valid_o}, 80'd1);
      check({req, " R5 start marker"}, {79'd0, phit_start_o}, {79'd0, (k == 0)});
      @(negedge clk);
    end
    check({req, " R6 idle after flit"}, {79'd0, phit_valid_o}, 80'd0);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [95:0] r;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1 ready in reset", {79'd0, pl_ready_o}, 80'd0);
    check("R1 valid in reset", {79'd0, phit_valid_o}, 80'd0);
    check("R1 start in reset", {79'd0, phit_start_o}, 80'd0);
    rst_n = 1'b1;
    @(negedge clk);
    send(72'h123456789abcdef012, 1'b0, "R1 no credits before init");

    do_init(3, 1'b1);
    check("R3 crc of known word", {72'd0, ref_crc(72'h0)}, 80'd0);
    send(72'h0, 1'b0, "R3 zero payload");
    send({72{1'b1}}, 1'b0, "R3 ones payload");
    send(72'h1, 1'b0, "R10 last credit");
    send(72'hdead, 1'b0, "R7 exhausted");
    send(72'hbeef, 1'b0, "R7 exhausted again");

    ret_pulse();
    send(72'h0f0f0f0f0f0f0f0f0f, 1'b1, "R8 return with accept");
    send(72'ha5a5a5a5a5a5a5a5a5, 1'b0, "R8 count held");
    send(72'h5a, 1'b0, "R8 now empty");

    do_init(2, 1'b0);
    ret_pulse(); ret_pulse(); ret_pulse();
    send(72'h800000000000000000, 1'b0, "R9 sat first");
    send(72'h7f, 1'b0, "R9 sat second");
    send(72'h3c, 1'b0, "R9 ceiling held");

    do_init(4, 1'b0);
    for (int it = 0; it < 60; it++) begin
      int op;
      op = $urandom_range(0, 2);
      r = {$urandom, $urandom, $urandom};
      if (op == 2) ret_pulse();
      else send(r[71:0], (op == 1), "R3 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule